// File: doc/BRIEF.md
# Audio Sample-Clock Generator with Master/Slave Select

This block produces the three clocks a serial audio link needs: an oversampling clock for converters, a bit clock and a word (left/right) clock. In master mode all three are divided down from a system clock that runs at 768 times the sample rate fs. They are built from one shared phase origin, so every edge of every output keeps a fixed relation to the others. Two static selects choose the oversampling rate (256fs or 384fs) and the bit-clock rate (32fs or 64fs).

In slave mode the bit and word clocks come from an external source. They are resynchronised into the system clock domain and driven out unchanged after a fixed latency, and the oversampling clock is held low. Any change of mode or of a rate select restarts every divider from a common zero phase on the next clock edge, so the outputs never drift apart after a reconfiguration.

Phase notation used below: in master mode, the phase p (0..767) counts system clock edges since the last restart. The outputs present after the restart edge carry phase 0, and p steps by one per edge, wrapping from 767 to 0.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst_n` is low, `mck_out`, `bck_out` and `lr_out` are all low, and they go low at once when reset is asserted.
- R2: In master mode `lr_out` is low for phases 0..383 and high for phases 384..767, so its period is 768 system clocks.
- R3: In master mode with `bck_64`=1 (64fs), `bck_out` has a period of 12 clocks: low when p mod 12 is 0..5 and high when it is 6..11.
- R4: In master mode with `bck_64`=0 (32fs), `bck_out` has a period of 24 clocks: low when p mod 24 is 0..11 and high when it is 12..23.
- R5: In master mode with `mck_384`=1 (384fs), `mck_out` has a period of 2 clocks and is high on even phases.
- R6: In master mode with `mck_384`=0 (256fs), `mck_out` has a period of 3 clocks: high when p mod 3 is 0 or 1 and low when it is 2.
- R7: In steady master operation, every transition of `lr_out` happens in the same cycle as a falling edge of `bck_out`.
- R8: Between two consecutive rising edges of `lr_out` in steady master operation there are exactly 64 rising edges of `bck_out` when `bck_64`=1 and exactly 32 when `bck_64`=0.
- R9: The first clock edge after reset release, and any edge at which `slave_mode`, `mck_384` or `bck_64` differs from its value at the previous edge, restarts the dividers. In master mode the outputs then show phase 0: `mck_out` high, `bck_out` low, `lr_out` low.
- R10: In slave mode `mck_out` is low, and `bck_out`/`lr_out` equal `bck_in`/`lr_in` as sampled three system clock edges earlier: two synchronizer stages plus the output register.
- R11: In slave mode a change of `mck_384` or `bck_64` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock, 768fs in master mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = pass external clocks through, 0 = generate clocks |
| mck_384 | input | 1 | Oversampling clock rate: 1 = 384fs, 0 = 256fs |
| bck_64 | input | 1 | Bit clock rate: 1 = 64fs, 0 = 32fs |
| bck_in | input | 1 | External bit clock used in slave mode |
| lr_in | input | 1 | External word clock used in slave mode |
| mck_out | output | 1 | Oversampling clock output |
| bck_out | output | 1 | Bit clock output |
| lr_out | output | 1 | Word clock output |

## Verification
A divider counter that is off by one, wraps at the wrong limit or misses a restart shows up at the ports within one period of the affected clock. For the oversampling clock that is two or three cycles, and for the bit clock twelve or twenty-four. A word-clock fault can stay hidden for up to 384 cycles, until the next half-frame boundary, where the bit-clock-per-frame count and the falling-edge alignment both expose it. A fault in the slave path is visible three cycles after the input toggles. For that reason the external clocks are driven with irregular patterns rather than clean square waves.

// File: rtl/acg_pkg.sv
package acg_pkg;

  // Configuration inputs that force a divider restart when they change.
  typedef struct packed {
    logic slave;
    logic mck_fast;
    logic bck_fast;
  } acg_sel_t;

  // The three generated clock levels, kept together for the output register.
  typedef struct packed {
    logic mck;
    logic bck;
    logic lr;
  } acg_clks_t;

endpackage

// File: rtl/acg_restart.sv
module acg_restart
  import acg_pkg::*;
(
  input  logic     clk_sys,
  input  logic     rst_n,
  input  acg_sel_t sel,
  output logic     restart
);

  acg_sel_t sel_q, sel_d;
  logic     run_q, run_d;

  // Restart on the first edge after reset and whenever any select moves.
  always_comb begin
    restart = !run_q || (sel != sel_q);
    sel_d   = sel;
    run_d   = 1'b1;
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      run_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/acg_divider.sv
// Counter divider whose modulus is chosen at run time between two values.
// It reports the level the output will take after the coming edge.
module acg_divider #(
  parameter int DIV_A      = 3,
  parameter int DIV_B      = 2,
  parameter bit HIGH_FIRST = 1'b1
) (
  input  logic clk_sys,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic use_b,
  output logic level_nxt
);

  localparam int DMAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int CW   = (DMAX > 1) ? $clog2(DMAX) : 1;
  localparam logic [CW-1:0] LIM_A = CW'(DIV_A - 1);
  localparam logic [CW-1:0] LIM_B = CW'(DIV_B - 1);
  // HIGH_FIRST: high while count < ceil(D/2). Otherwise: high once count >= floor(D/2).
  localparam logic [CW-1:0] THR_A = HIGH_FIRST ? CW'(DIV_A - DIV_A / 2) : CW'(DIV_A / 2);
  localparam logic [CW-1:0] THR_B = HIGH_FIRST ? CW'(DIV_B - DIV_B / 2) : CW'(DIV_B / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim, thr;

  always_comb begin
    lim = use_b ? LIM_B : LIM_A;
    thr = use_b ? THR_B : THR_A;
    if (restart) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = (cnt_q == lim) ? '0 : CW'(cnt_q + 1'b1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  generate
    if (HIGH_FIRST) begin : g_high_first
      assign level_nxt = (cnt_d < thr);
    end else begin : g_low_first
      assign level_nxt = (cnt_d >= thr);
    end
  endgenerate

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/acg_sync.sv
// Multi-stage synchronizer for the external clocks used in slave mode.
module acg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_sys,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  generate
    if (STAGES == 1) begin : g_single
      assign stg_d = d;
    end else begin : g_chain
      assign stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int FRAME_DIV   = 768,
  parameter int MCK_DIV_256 = 3,
  parameter int MCK_DIV_384 = 2,
  parameter int BCK_DIV_32  = 24,
  parameter int BCK_DIV_64  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_sys,
  input  logic rst_n,
  input  logic slave_mode,
  input  logic mck_384,
  input  logic bck_64,
  input  logic bck_in,
  input  logic lr_in,
  output logic mck_out,
  output logic bck_out,
  output logic lr_out
);

  acg_sel_t  sel;
  acg_clks_t gen_nxt, clks_d, clks_q;
  logic      restart;
  logic      div_en;
  logic [1:0] ext_sync;

  assign sel    = '{slave: slave_mode, mck_fast: mck_384, bck_fast: bck_64};
  assign div_en = !slave_mode;

  acg_restart u_restart (
    .clk_sys (clk_sys),
    .rst_n   (rst_n),
    .sel     (sel),
    .restart (restart)
  );

  // Oversampling clock: high-first so the odd divide gives 2 high / 1 low.
  acg_divider #(.DIV_A(MCK_DIV_256), .DIV_B(MCK_DIV_384), .HIGH_FIRST(1'b1)) u_mck_div (
    .clk_sys   (clk_sys),
    .rst_n     (rst_n),
    .en        (div_en),
    .restart   (restart),
    .use_b     (mck_384),
    .level_nxt (gen_nxt.mck)
  );

  // Bit clock: low-first so it falls at phase 0 together with the word clock.
  acg_divider #(.DIV_A(BCK_DIV_32), .DIV_B(BCK_DIV_64), .HIGH_FIRST(1'b0)) u_bck_div (
    .clk_sys   (clk_sys),
    .rst_n     (rst_n),
    .en        (div_en),
    .restart   (restart),
    .use_b     (bck_64),
    .level_nxt (gen_nxt.bck)
  );

  acg_divider #(.DIV_A(FRAME_DIV), .DIV_B(FRAME_DIV), .HIGH_FIRST(1'b0)) u_frame_div (
    .clk_sys   (clk_sys),
    .rst_n     (rst_n),
    .en        (div_en),
    .restart   (restart),
    .use_b     (1'b0),
    .level_nxt (gen_nxt.lr)
  );

  acg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_sys (clk_sys),
    .rst_n   (rst_n),
    .d       ({bck_in, lr_in}),
    .q       (ext_sync)
  );

  always_comb begin
    if (slave_mode) begin
      clks_d = '{mck: 1'b0, bck: ext_sync[1], lr: ext_sync[0]};
    end else begin
      clks_d = gen_nxt;
    end
  end

  // All outputs leave from flops, so no combinational glitch reaches a pin.
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      clks_q <= '0;
    end else begin
      clks_q <= clks_d;
    end
  end

  assign mck_out = clks_q.mck;
  assign bck_out = clks_q.bck;
  assign lr_out  = clks_q.lr;

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk_sys,
  input logic rst_n,
  input logic slave_mode,
  input logic mck_384,
  input logic bck_64,
  input logic bck_in,
  input logic lr_in,
  input logic mck_out,
  input logic bck_out,
  input logic lr_out
);

  logic [1:0] age_q;
  logic [2:0] sel_v;

  assign sel_v = {slave_mode, mck_384, bck_64};

  // Counts edges since reset release, saturating at 3.
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R5
  mck_fast_toggle_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (age_q >= 2'd2 && !$past(slave_mode) && $past(mck_384) && $past(sel_v) == $past(sel_v, 2))
    |-> (mck_out != $past(mck_out)));

  // R7
  lr_on_bck_fall_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (age_q >= 2'd2 && !$past(slave_mode) && $past(sel_v) == $past(sel_v, 2)
     && lr_out != $past(lr_out))
    |-> (!bck_out && $past(bck_out)));

  // R9
  restart_phase_zero_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (age_q >= 2'd2 && !$past(slave_mode) && $past(sel_v) != $past(sel_v, 2))
    |-> (mck_out && !bck_out && !lr_out));

  // R10
  slave_mck_low_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $past(slave_mode) |-> !mck_out);

  // R10
  slave_passthru_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (age_q == 2'd3 && $past(slave_mode))
    |-> (bck_out == $past(bck_in, 3) && lr_out == $past(lr_in, 3)));

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (.*);

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;

  logic clk_sys = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic mck_384 = 1'b1;
  logic bck_64 = 1'b1;
  logic bck_in = 1'b0;
  logic lr_in = 1'b0;
  logic mck_out, bck_out, lr_out;

  int n_chk = 0;
  int n_err = 0;
  bit r11_window = 1'b0;
  bit done = 1'b0;

  always #5 clk_sys = ~clk_sys;

  audio_clkgen u0 (
    .clk_sys (clk_sys), .rst_n (rst_n), .slave_mode (slave_mode),
    .mck_384 (mck_384), .bck_64 (bck_64), .bck_in (bck_in), .lr_in (lr_in),
    .mck_out (mck_out), .bck_out (bck_out), .lr_out (lr_out)
  );

  // Behavioural reference model
  int  ph = 0;
  bit  started = 1'b0;
  bit  [2:0] sel_prev = '0;
  bit  h1_b = 0, h1_l = 0, h2_b = 0, h2_l = 0;
  bit  e_mck = 0, e_bck = 0, e_lr = 0;
  bit  restart_ev = 0, in_reset = 1;

  always @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      started = 0; sel_prev = '0; ph = 0;
      h1_b = 0; h1_l = 0; h2_b = 0; h2_l = 0;
      e_mck = 0; e_bck = 0; e_lr = 0; restart_ev = 0; in_reset = 1;
    end else begin
      int per;
      in_reset = 0;
      restart_ev = !started || (sel_prev != {slave_mode, mck_384, bck_64});
      if (restart_ev) ph = 0;
      else if (!slave_mode) ph = (ph + 1) % 768;
      started = 1;
      sel_prev = {slave_mode, mck_384, bck_64};
      if (slave_mode) begin
        e_mck = 0; e_bck = h2_b; e_lr = h2_l;
      end else begin
        per = bck_64 ? 12 : 24;
        e_mck = mck_384 ? (ph % 2 == 0) : (ph % 3 != 2);
        e_bck = (ph % per) >= per / 2;
        e_lr  = ph >= 384;
      end
      h2_b = h1_b; h2_l = h1_l;
      h1_b = bck_in; h1_l = lr_in;
    end
  end

  // Comparison away from the active edge
  bit p_bck = 0, p_lr = 0, frame_ok = 0;
  int bck_rises = 0;

  always @(negedge clk_sys) begin
    if (!done) begin
      string tag;
      n_chk++;
      if ({mck_out, bck_out, lr_out} != {e_mck, e_bck, e_lr}) begin
        if (in_reset) tag = "R1";
        else if (slave_mode) tag = r11_window ? "R11" : "R10";
        else if (restart_ev) tag = "R9";
        else if (mck_out != e_mck) tag = mck_384 ? "R5" : "R6";
        else if (bck_out != e_bck) tag = bck_64 ? "R3" : "R4";
        else tag = "R2";
        n_err++;
        $display("FAIL %s: mck/bck/lr got %b%b%b expected %b%b%b at %0t",
                 tag, mck_out, bck_out, lr_out, e_mck, e_bck, e_lr, $time);
      end
      if (in_reset || slave_mode || restart_ev) begin
        frame_ok = 0; bck_rises = 0;
      end else begin
        // R7: a word clock edge must coincide with a bit clock fall
        if (lr_out != p_lr) begin
          n_chk++;
          if (!(p_bck && !bck_out)) begin
            n_err++;
            $display("FAIL R7: bck prev/now got %b%b expected 10", p_bck, bck_out);
          end
        end
        if (bck_out && !p_bck) bck_rises++;
        // R8: bit clocks per frame
        if (lr_out && !p_lr) begin
          if (frame_ok) begin
            n_chk++;
            if (bck_rises != (bck_64 ? 64 : 32)) begin
              n_err++;
              $display("FAIL R8: bck rises got %0d expected %0d", bck_rises, bck_64 ? 64 : 32);
            end
          end
          frame_ok = 1; bck_rises = 0;
        end
      end
      p_bck = bck_out; p_lr = lr_out;
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk_sys); #2;
    end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    // R1: reset state
    step(5);
    rst_n = 1'b1;
    // R2 R3 R5 R8: 64fs bit clock, 384fs oversampling
    step(2000);
    // R4 R9: switch to 32fs mid-frame
    bck_64 = 1'b0;
    step(1700);
    // R6 R9: 256fs oversampling
    mck_384 = 1'b0;
    step(1700);
    bck_64 = 1'b1;
    step(1700);
    // R1: asynchronous reset in mid-run
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(900);
    // R10: slave pass-through with irregular external clocks
    slave_mode = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      bck_in = i[1] ^ (i % 7 == 0);
      lr_in  = i[5] | (i % 11 == 3);
      if (i == 600) begin
        // R11: rate selects changed while in slave mode
        r11_window = 1'b1;
        mck_384 = 1'b1;
      end
      if (i == 900) bck_64 = 1'b0;
      step(1);
    end
    r11_window = 1'b0;
    // R9: back to master restarts from phase zero
    slave_mode = 1'b0;
    step(1800);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk_sys);
    n_err++;
    $display("FAIL watchdog: run got no end expected end before timeout");
    summary();
  end

endmodule